// File: doc/BRIEF.md
# Accumulator Arithmetic Unit with Status Flags

This block is the arithmetic core of a byte-wide accumulator machine. It holds three architectural registers: the accumulator, a second operand register (called B here), and an 8-bit status word. Each operation it executes updates the accumulator and, where needed, B and the arithmetic flags. The operations are add, add with carry-in, subtract with borrow, multiply, divide, and a plain load of the accumulator. The flags are carry, half-carry, signed overflow and accumulator parity.

An operation is issued with `op_valid` for one clock. It completes at that clock edge, and its result is visible on the outputs in the following cycle. The block accepts one operation per cycle and never stalls, so it has no back-pressure and no ready signal. With `op_valid` low, software can load the accumulator, B or the status word directly from `operand` through the write strobes. Two user bits and a two-bit bank-select field in the status word belong to software, and arithmetic leaves them alone.

Top module: `acc_alu_core`

## Requirements
- R1: After reset the accumulator, B and every status word bit read zero.
- R2: ADD (code 0) writes A+operand to the accumulator, and ADDC (code 1) writes A+operand+CY. Status bit 7 (CY) is set exactly when the sum carries out of bit 7.
- R3: Status bit 6 (AC) is set by ADD/ADDC when the low nibbles carry into bit 4. SUBB sets it when the low nibble needs a borrow. It is otherwise cleared by every arithmetic code (0 to 4).
- R4: Status bit 2 (OV) is set by ADD/ADDC/SUBB exactly on two's-complement overflow of the 8-bit result.
- R5: SUBB (code 2) writes A-operand-CY to the accumulator and sets CY exactly when a borrow is needed.
- R6: MUL (code 3) writes the low byte of A*B to the accumulator and the high byte to B. It sets OV when the product exceeds 255, clears OV otherwise, and always clears CY.
- R7: DIV (code 4) writes the quotient A/B to the accumulator and the remainder to B, and clears CY and OV. When B is zero it sets OV, clears CY and leaves the accumulator and B unchanged.
- R8: Status bit 0 (P) always equals the XOR of the accumulator bits. It takes the new value in the same cycle as the new accumulator value, whether that value came from arithmetic, from LOAD (code 5, accumulator = operand, flags unchanged) or from a direct write. A status word write cannot change P.
- R9: Status bits 5 (F0), 4:3 (RS) and 1 (F1) are never changed by any operation code.
- R10: With `op_valid` low, `wr_acc`, `wr_b` and `wr_psw` load `operand` into the accumulator, B, or status bits 7:1 respectively. While `op_valid` is high all write strobes are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Execute `op_code` this cycle |
| op_code | input | 3 | 0 ADD, 1 ADDC, 2 SUBB, 3 MUL, 4 DIV, 5 LOAD |
| operand | input | 8 | Second operand, load value or direct write data |
| wr_acc | input | 1 | Direct accumulator write |
| wr_b | input | 1 | Direct B write |
| wr_psw | input | 1 | Direct status word write (bits 7:1) |
| acc_o | output | 8 | Accumulator |
| b_o | output | 8 | B register |
| psw_o | output | 8 | Status word {CY,AC,F0,RS[1:0],OV,F1,P} |

## Verification
Every architectural register is visible at the outputs, so a wrong next-state value shows up one cycle after the operation that produced it. A corrupted carry, however, may only show at a later add-with-carry or subtract, through the value it feeds in. The bench therefore chains carry-consuming operations behind carry-producing ones and compares all three outputs after every cycle. A parity bit that lags the accumulator shows as a one-cycle mismatch on `psw_o[0]` after direct writes and loads.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;
  typedef enum logic [2:0] {
    OP_ADD  = 3'd0,
    OP_ADDC = 3'd1,
    OP_SUBB = 3'd2,
    OP_MUL  = 3'd3,
    OP_DIV  = 3'd4,
    OP_LOAD = 3'd5
  } alu_op_e;

  // status word bit positions (fixed by the register layout)
  localparam int unsigned PS_CY = 7;
  localparam int unsigned PS_AC = 6;
  localparam int unsigned PS_F0 = 5;
  localparam int unsigned PS_RS = 3;
  localparam int unsigned PS_OV = 2;
  localparam int unsigned PS_F1 = 1;
  localparam int unsigned PS_P  = 0;
endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         cin_i,
  input  logic         sub_i,
  output logic [W-1:0] res_o,
  output logic         cy_o,
  output logic         ac_o,
  output logic         ov_o
);
  localparam int unsigned H = W / 2;

  logic [W:0]   full;
  logic [H:0]   half;
  logic [W-1:0] low7;

  always_comb begin
    if (sub_i) begin
      full = {1'b0, a_i} - {1'b0, b_i} - {{W{1'b0}}, cin_i};
      half = {1'b0, a_i[H-1:0]} - {1'b0, b_i[H-1:0]} - {{H{1'b0}}, cin_i};
      low7 = '0;
      ov_o = (a_i[W-1] != b_i[W-1]) && (full[W-1] != a_i[W-1]);
    end else begin
      full = {1'b0, a_i} + {1'b0, b_i} + {{W{1'b0}}, cin_i};
      half = {1'b0, a_i[H-1:0]} + {1'b0, b_i[H-1:0]} + {{H{1'b0}}, cin_i};
      low7 = {1'b0, a_i[W-2:0]} + {1'b0, b_i[W-2:0]} + {{(W-1){1'b0}}, cin_i};
      ov_o = full[W] ^ low7[W-1];
    end
    res_o = full[W-1:0];
    cy_o  = full[W];
    ac_o  = half[H];
  end

  // an addition can only overflow when both inputs share a sign
  always_comb begin
    if (!sub_i && ov_o)
      p_add_ovf_sign_r4: assert (a_i[W-1] == b_i[W-1]);
  end
endmodule

// File: rtl/alu_muldiv.sv
module alu_muldiv #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] prod_lo_o,
  output logic [W-1:0] prod_hi_o,
  output logic         mul_ov_o,
  output logic [W-1:0] quo_o,
  output logic [W-1:0] rem_o,
  output logic         div_zero_o
);
  logic [2*W-1:0] prod;

  always_comb begin
    prod       = {{W{1'b0}}, a_i} * {{W{1'b0}}, b_i};
    prod_lo_o  = prod[W-1:0];
    prod_hi_o  = prod[2*W-1:W];
    mul_ov_o   = |prod[2*W-1:W];
    div_zero_o = (b_i == '0);
    quo_o      = div_zero_o ? a_i : (a_i / b_i);
    rem_o      = div_zero_o ? b_i : (a_i % b_i);
  end

  always_comb begin
    if (!div_zero_o)
      p_rem_below_divisor_r7: assert (rem_o < b_i);
  end
endmodule

// File: rtl/acc_alu_core.sv
module acc_alu_core
  import acc_alu_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         op_valid,
  input  logic [2:0]   op_code,
  input  logic [W-1:0] operand,
  input  logic         wr_acc,
  input  logic         wr_b,
  input  logic         wr_psw,
  output logic [W-1:0] acc_o,
  output logic [W-1:0] b_o,
  output logic [7:0]   psw_o
);
  logic [W-1:0] acc_q, acc_d, b_q, b_d;
  logic         cy_q, cy_d, ac_q, ac_d, ov_q, ov_d;
  logic         f0_q, f0_d, f1_q, f1_d;
  logic [1:0]   rs_q, rs_d;

  logic [W-1:0] as_res;
  logic         as_cy, as_ac, as_ov, as_sub, as_cin;
  logic [W-1:0] md_lo, md_hi, md_quo, md_rem;
  logic         md_ov, md_dz;
  alu_op_e      op;

  assign op     = alu_op_e'(op_code);
  assign as_sub = (op == OP_SUBB);
  assign as_cin = (op == OP_ADD) ? 1'b0 : cy_q;

  alu_addsub #(.W(W)) u_addsub (
    .a_i(acc_q), .b_i(operand), .cin_i(as_cin), .sub_i(as_sub),
    .res_o(as_res), .cy_o(as_cy), .ac_o(as_ac), .ov_o(as_ov)
  );

  alu_muldiv #(.W(W)) u_muldiv (
    .a_i(acc_q), .b_i(b_q),
    .prod_lo_o(md_lo), .prod_hi_o(md_hi), .mul_ov_o(md_ov),
    .quo_o(md_quo), .rem_o(md_rem), .div_zero_o(md_dz)
  );

  always_comb begin
    acc_d = acc_q; b_d = b_q;
    cy_d = cy_q; ac_d = ac_q; ov_d = ov_q;
    f0_d = f0_q; f1_d = f1_q; rs_d = rs_q;
    if (op_valid) begin
      unique case (op)
        OP_ADD, OP_ADDC, OP_SUBB: begin
          acc_d = as_res; cy_d = as_cy; ac_d = as_ac; ov_d = as_ov;
        end
        OP_MUL: begin
          acc_d = md_lo; b_d = md_hi; cy_d = 1'b0; ac_d = 1'b0; ov_d = md_ov;
        end
        OP_DIV: begin
          cy_d = 1'b0; ac_d = 1'b0; ov_d = md_dz;
          if (!md_dz) begin
            acc_d = md_quo; b_d = md_rem;
          end
        end
        OP_LOAD: acc_d = operand;
        default: ;
      endcase
    end else begin
      if (wr_acc) acc_d = operand;
      if (wr_b)   b_d   = operand;
      if (wr_psw) begin
        cy_d = operand[PS_CY]; ac_d = operand[PS_AC]; f0_d = operand[PS_F0];
        rs_d = operand[PS_RS+1:PS_RS]; ov_d = operand[PS_OV]; f1_d = operand[PS_F1];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0; b_q <= '0;
      cy_q <= 1'b0; ac_q <= 1'b0; ov_q <= 1'b0;
      f0_q <= 1'b0; f1_q <= 1'b0; rs_q <= 2'b00;
    end else begin
      acc_q <= acc_d; b_q <= b_d;
      cy_q <= cy_d; ac_q <= ac_d; ov_q <= ov_d;
      f0_q <= f0_d; f1_q <= f1_d; rs_q <= rs_d;
    end
  end

  assign acc_o = acc_q;
  assign b_o   = b_q;
  assign psw_o = {cy_q, ac_q, f0_q, rs_q, ov_q, f1_q, ^acc_q};

  p_user_bits_kept_r9: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid |=> (f0_q == $past(f0_q)) && (f1_q == $past(f1_q)) && (rs_q == $past(rs_q)));

  p_mul_clears_cy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == 3'd3) |=> !psw_o[PS_CY]);

  p_div_zero_flags_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == 3'd4 && b_o == '0) |=> psw_o[PS_OV] && !psw_o[PS_CY] && $stable(acc_o));

  p_wr_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && wr_b && op_code <= 3'd2) |=> $stable(b_o));

  p_load_value_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == 3'd5) |=> acc_o == $past(operand));
endmodule

// File: tb/tb_acc_alu_core.sv
module tb_acc_alu_core;
  localparam int CLK_PERIOD = 10;

  typedef struct {
    logic [7:0] acc;
    logic [7:0] b;
    logic [7:0] psw;
    string      req;
  } exp_t;

  logic       clk = 1'b0, rst_n = 1'b0;
  logic       op_valid = 1'b0, wr_acc = 1'b0, wr_b = 1'b0, wr_psw = 1'b0;
  logic [2:0] op_code = 3'd0;
  logic [7:0] operand = 8'd0;
  logic [7:0] acc_o, b_o, psw_o;

  int checks = 0, bad = 0;
  exp_t q[$];

  logic [7:0] m_acc = 0, m_b = 0;
  logic m_cy = 0, m_ac = 0, m_f0 = 0, m_ov = 0, m_f1 = 0;
  logic [1:0] m_rs = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  acc_alu_core dut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
    .operand(operand), .wr_acc(wr_acc), .wr_b(wr_b), .wr_psw(wr_psw),
    .acc_o(acc_o), .b_o(b_o), .psw_o(psw_o)
  );

  function automatic logic [7:0] m_psw();
    return {m_cy, m_ac, m_f0, m_rs, m_ov, m_f1, ^m_acc};
  endfunction

  task automatic compare(input string req, input string what,
                         input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%02h expected=%02h", req, what, act, exp);
    end
  endtask

  task automatic step(input logic v, input logic [2:0] op, input logic [7:0] d,
                      input logic wa, input logic wb, input logic wp, input string req);
    int s, a, x;
    exp_t e;
    @(negedge clk);
    op_valid = v; op_code = op; operand = d; wr_acc = wa; wr_b = wb; wr_psw = wp;
    a = m_acc; x = d;
    if (v) begin
      case (op)
        3'd0, 3'd1: begin
          s = a + x + ((op == 3'd1) ? int'(m_cy) : 0);
          m_ac = ((a & 15) + (x & 15) + ((op == 3'd1) ? int'(m_cy) : 0)) > 15;
          m_ov = (((a ^ s) & (x ^ s) & 8'h80) != 0);
          m_cy = s > 255; m_acc = s[7:0];
        end
        3'd2: begin
          s = a - x - int'(m_cy);
          m_ac = (a & 15) < ((x & 15) + int'(m_cy));
          m_ov = (((a ^ x) & (a ^ s) & 8'h80) != 0);
          m_cy = s < 0; m_acc = s[7:0];
        end
        3'd3: begin
          s = a * int'(m_b);
          m_acc = s[7:0]; m_b = s[15:8]; m_ov = s > 255; m_cy = 0; m_ac = 0;
        end
        3'd4: begin
          m_cy = 0; m_ac = 0;
          if (m_b == 0) m_ov = 1;
          else begin
            m_ov = 0; s = a / int'(m_b); m_b = 8'(a % int'(m_b)); m_acc = s[7:0];
          end
        end
        3'd5: m_acc = d;
        default: ;
      endcase
    end else begin
      if (wa) m_acc = d;
      if (wb) m_b = d;
      if (wp) begin
        m_cy = d[7]; m_ac = d[6]; m_f0 = d[5]; m_rs = d[4:3]; m_ov = d[2]; m_f1 = d[1];
      end
    end
    e.acc = m_acc; e.b = m_b; e.psw = m_psw(); e.req = req;
    q.push_back(e);
  endtask

  // monitor: one expected item per clock, sampled a quarter period after the edge
  always @(posedge clk) begin
    #(CLK_PERIOD/4);
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      compare(e.req, "acc", acc_o, e.acc);
      compare(e.req, "b",   b_o,   e.b);
      compare(e.req, "psw", psw_o, e.psw);
    end
  end

  initial begin
    #(CLK_PERIOD*5000);
    checks++; bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    // R1: reset state
    compare("R1", "acc", acc_o, 8'h00);
    compare("R1", "b",   b_o,   8'h00);
    compare("R1", "psw", psw_o, 8'h00);
    rst_n = 1'b1;

    step(0, 0, 8'h3C, 1, 0, 0, "R10 acc write");
    step(0, 0, 8'h07, 1, 0, 0, "R8 parity after write");
    step(0, 0, 8'hFF, 0, 0, 1, "R8 R9 psw write keeps P");
    step(1, 1, 8'h01, 0, 0, 0, "R2 R9 addc with carry");
    step(0, 0, 8'h7F, 1, 0, 0, "R10 acc write");
    step(1, 0, 8'h01, 0, 0, 0, "R4 R3 add overflow");
    step(0, 0, 8'hFF, 1, 0, 0, "R10 acc write");
    step(1, 0, 8'h01, 0, 0, 0, "R2 R3 add carry out");
    step(1, 1, 8'h00, 0, 0, 0, "R2 addc consumes carry");
    step(0, 0, 8'h80, 1, 0, 0, "R10 acc write");
    step(1, 2, 8'h01, 0, 0, 0, "R5 R4 R3 subb overflow");
    step(0, 0, 8'h00, 1, 0, 0, "R10 acc write");
    step(1, 2, 8'h01, 0, 0, 0, "R5 R3 subb borrow");
    step(1, 2, 8'h10, 0, 0, 0, "R5 subb uses borrow");
    step(0, 0, 8'h10, 1, 0, 0, "R10 acc write");
    step(0, 0, 8'h20, 0, 1, 0, "R10 b write");
    step(1, 3, 8'h00, 0, 0, 0, "R6 mul overflow");
    step(0, 0, 8'h03, 1, 1, 0, "R10 acc b write");
    step(0, 0, 8'h05, 0, 1, 0, "R10 b write");
    step(1, 3, 8'h00, 0, 0, 0, "R6 mul small");
    step(0, 0, 8'd100, 1, 0, 0, "R10 acc write");
    step(0, 0, 8'd7, 0, 1, 0, "R10 b write");
    step(1, 4, 8'h00, 0, 0, 0, "R7 divide");
    step(0, 0, 8'h00, 0, 1, 0, "R10 b zero");
    step(1, 4, 8'h00, 0, 0, 0, "R7 divide by zero");
    step(1, 0, 8'h55, 1, 1, 1, "R10 strobes ignored during op");
    step(1, 5, 8'hA1, 0, 0, 0, "R8 load parity");
    step(0, 0, 8'h01, 0, 0, 1, "R8 psw write cannot set P");
    step(0, 0, 8'h1A, 0, 0, 1, "R9 user bits write");
    for (int i = 0; i < 60; i++) begin
      step(1, 3'($urandom_range(0, 5)), 8'($urandom), 0, 0, 0, "R9 R2 R5 R6 R7 mixed");
      if (i % 7 == 0) step(0, 0, 8'($urandom), 0, 1, 0, "R10 b refresh");
    end
    step(0, 0, 8'h00, 0, 0, 0, "R9 idle");
    repeat (3) @(negedge clk);
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule